// File: doc/BRIEF.md
# Half-Offset Circular Audio Loopback Buffer

This block keeps one circular store of stereo sample frames that an audio receive path fills and an audio transmit path drains, so that whatever arrives is played back again after a fixed delay. Each frame packs a left and a right signed 16-bit channel. The transmit side pulls one frame per request and sees the data one cycle later. The receive side pushes one frame per strobe. Each side keeps its own pointer, and both pointers wrap around the store without outside help.

A four-state start-up controller drives the sequence. When asked to start, it zero-fills the store and then lets playback run alone. Capture is switched on only in the cycle in which playback raises its midpoint event. From then on the write pointer trails the read pointer by half the store. With equal sample rates, every captured frame comes back out exactly half a store later. Each direction pulses a midpoint event and a wrap event, and two debug levels follow those events so the phase relation can be watched from outside.

Top module: `echo_ring_buf`

## Requirements
- R1: While reset is held and after it is released, `state_o` is 0 (idle) and `tx_valid_o`, all four event outputs and `dbg_o` are low.
- R2: The controller state is encoded as idle=0, zero-fill=1, playback-only=2, running=3. A `start_i` pulse in idle enters zero-fill. Zero-fill writes zero to every one of the FRAMES frames, one per cycle, and then moves to playback-only.
- R3: A cycle with `tx_req_i` high gives `tx_valid_o` high in the next cycle, and low otherwise. In playback-only and running, the data is the frame at the read pointer, with the left channel in bits [31:16] and the right channel in [15:0]. The read pointer then advances and wraps from FRAMES-1 to 0.
- R4: A request made in idle or zero-fill is answered with all-zero data and does not move the read pointer.
- R5: The controller enters running in the same cycle that `tx_half_o` pulses. Receive strobes before that cycle are ignored.
- R6: In running, each `rx_stb_i` writes `rx_data_i` to the write pointer, which starts at frame 0 and wraps after FRAMES-1. `rx_half_o` / `rx_done_o` pulse for one cycle after frame FRAMES/2-1 / FRAMES-1 is written.
- R7: `tx_half_o` / `tx_done_o` pulse for one cycle, together with `tx_valid_o`, after frame FRAMES/2-1 / FRAMES-1 is read.
- R8: `dbg_o[0]` rises with `tx_half_o` and falls with `tx_done_o`. `dbg_o[1]` does the same with the receive events.
- R9: With one request and one strobe in every cycle of running, the data played back equals the data captured FRAMES/2 frames earlier. The first FRAMES/2 frames played after capture starts are zero.
- R10: A read and a write of the same frame in one cycle return the frame's previous content, and the new data is returned on the next pass.
- R11: `stop_i` takes priority over every other input. In its cycle it blocks all reads, writes and events and answers any request with zero. In the next cycle the state is idle, both pointers are 0 and `dbg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, acted on in idle |
| stop_i | input | 1 | Synchronous return to idle |
| tx_req_i | input | 1 | Playback frame request |
| tx_valid_o | output | 1 | Playback data valid, one cycle after request |
| tx_data_o | output | 2*CH_W | Playback frame, left channel in the upper half |
| rx_stb_i | input | 1 | Capture frame strobe |
| rx_data_i | input | 2*CH_W | Capture frame, left channel in the upper half |
| tx_half_o | output | 1 | Playback midpoint event pulse |
| tx_done_o | output | 1 | Playback wrap event pulse |
| rx_half_o | output | 1 | Capture midpoint event pulse |
| rx_done_o | output | 1 | Capture wrap event pulse |
| dbg_o | output | 2 | Debug levels: [0] playback, [1] capture |
| state_o | output | 2 | Controller state |

## Verification
The properties assume that `stop_i`, `start_i`, `tx_req_i` and `rx_stb_i` are clean, clock-synchronous levels that hold a known value from reset onwards. They also assume that FRAMES is at least 4, so an event pulse can never repeat in the next cycle. The stimulus changes inputs only on the falling edge and draws every control bit from a seeded `$urandom`. It adds directed runs that drive a request and a strobe in every cycle to check the half-store delay. Other directed runs force the read and write pointers onto the same frame, and assert stop and start together.

// File: rtl/echo_ring_pkg.sv
package echo_ring_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CLEAR  = 2'd1,
      ST_TXONLY = 2'd2,
      ST_RUN    = 2'd3
   } ring_state_e;

   localparam int unsigned NUM_DIR = 2;
   localparam int unsigned DIR_TX  = 0;
   localparam int unsigned DIR_RX  = 1;
endpackage

// File: rtl/echo_ring_ptr.sv
module echo_ring_ptr #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [AW-1:0] ptr_o,
   output logic          half_hit_o,
   output logic          last_hit_o
);
   localparam logic [AW-1:0] HALF_IDX = AW'(DEPTH / 2 - 1);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr_q <= '0;
      else if (clr_i)  ptr_q <= '0;
      else if (adv_i)  ptr_q <= ptr_q + AW'(1);
   end

   assign ptr_o      = ptr_q;
   assign half_hit_o = adv_i && !clr_i && (ptr_q == HALF_IDX);
   assign last_hit_o = adv_i && !clr_i && (ptr_q == LAST_IDX);
endmodule

// File: rtl/echo_ring_mem.sv
module echo_ring_mem #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned AW    = $clog2(DEPTH),
   parameter int unsigned DW    = 32
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] store [DEPTH];
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we_i) store[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (re_i) rdata_q <= store[raddr_i];
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/echo_ring_ctrl.sv
module echo_ring_ctrl
   import echo_ring_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        stop_i,
   input  logic        fill_done_i,
   input  logic        tx_half_i,
   output ring_state_e state_o
);
   ring_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (stop_i) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE:   if (start_i)     st_d = ST_CLEAR;
            ST_CLEAR:  if (fill_done_i) st_d = ST_TXONLY;
            ST_TXONLY: if (tx_half_i)   st_d = ST_RUN;
            default:                    st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;
endmodule

// File: rtl/echo_ring_buf.sv
module echo_ring_buf
   import echo_ring_pkg::*;
#(
   parameter int unsigned FRAMES = 1024,
   parameter int unsigned CH_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              tx_req_i,
   output logic              tx_valid_o,
   output logic [2*CH_W-1:0] tx_data_o,
   input  logic              rx_stb_i,
   input  logic [2*CH_W-1:0] rx_data_i,
   output logic              tx_half_o,
   output logic              tx_done_o,
   output logic              rx_half_o,
   output logic              rx_done_o,
   output logic [1:0]        dbg_o,
   output logic [1:0]        state_o
);
   localparam int unsigned AW = $clog2(FRAMES);
   localparam int unsigned FW = 2 * CH_W;

   if (FRAMES < 4 || (FRAMES & (FRAMES - 1)) != 0) begin : g_bad_frames
      $error("echo_ring_buf: FRAMES must be a power of two and at least 4");
   end
   if (CH_W < 1) begin : g_bad_width
      $error("echo_ring_buf: CH_W must be at least 1");
   end

   ring_state_e   state;
   logic          tx_active, tx_adv, clearing, rx_cap, wr_adv, ptr_clr;
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [FW-1:0] rd_data, wr_data;
   logic [NUM_DIR-1:0] half_hit, last_hit, half_set, last_set;
   logic [NUM_DIR-1:0] half_q, done_q, dbg_q;
   logic          valid_q, zero_q;

   assign tx_active = (state == ST_TXONLY || state == ST_RUN) && !stop_i;
   assign tx_adv    = tx_req_i && tx_active;
   assign clearing  = (state == ST_CLEAR) && !stop_i;
   assign rx_cap    = (state == ST_RUN) && rx_stb_i && !stop_i;
   assign wr_adv    = clearing || rx_cap;
   assign ptr_clr   = stop_i || (state == ST_IDLE);
   assign wr_data   = clearing ? '0 : rx_data_i;

   echo_ring_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .fill_done_i (clearing && last_hit[DIR_RX]),
      .tx_half_i   (half_hit[DIR_TX]),
      .state_o     (state)
   );

   echo_ring_ptr #(.DEPTH(FRAMES), .AW(AW)) u_rd_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (ptr_clr),
      .adv_i      (tx_adv),
      .ptr_o      (rd_ptr),
      .half_hit_o (half_hit[DIR_TX]),
      .last_hit_o (last_hit[DIR_TX])
   );

   echo_ring_ptr #(.DEPTH(FRAMES), .AW(AW)) u_wr_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (ptr_clr),
      .adv_i      (wr_adv),
      .ptr_o      (wr_ptr),
      .half_hit_o (half_hit[DIR_RX]),
      .last_hit_o (last_hit[DIR_RX])
   );

   echo_ring_mem #(.DEPTH(FRAMES), .AW(AW), .DW(FW)) u_mem (
      .clk     (clk),
      .we_i    (wr_adv),
      .waddr_i (wr_ptr),
      .wdata_i (wr_data),
      .re_i    (tx_adv),
      .raddr_i (rd_ptr),
      .rdata_o (rd_data)
   );

   // Events and debug levels, one lane per direction. Capture-side pointer
   // advances during zero-fill raise no event.
   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      if (d == DIR_RX) begin : g_gate
         assign half_set[d] = half_hit[d] && rx_cap;
         assign last_set[d] = last_hit[d] && rx_cap;
      end else begin : g_pass
         assign half_set[d] = half_hit[d];
         assign last_set[d] = last_hit[d];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            half_q[d] <= 1'b0;
            done_q[d] <= 1'b0;
            dbg_q[d]  <= 1'b0;
         end else begin
            half_q[d] <= half_set[d];
            done_q[d] <= last_set[d];
            if (stop_i)           dbg_q[d] <= 1'b0;
            else if (half_set[d]) dbg_q[d] <= 1'b1;
            else if (last_set[d]) dbg_q[d] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         zero_q  <= 1'b1;
      end else begin
         valid_q <= tx_req_i;
         if (tx_req_i) zero_q <= !tx_adv;
      end
   end

   assign tx_valid_o = valid_q;
   assign tx_data_o  = zero_q ? '0 : rd_data;
   assign tx_half_o  = half_q[DIR_TX];
   assign tx_done_o  = done_q[DIR_TX];
   assign rx_half_o  = half_q[DIR_RX];
   assign rx_done_o  = done_q[DIR_RX];
   assign dbg_o      = dbg_q;
   assign state_o    = state;
endmodule

// File: rtl/echo_ring_chk.sv
module echo_ring_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_i,
   input logic       tx_req_i,
   input logic       tx_valid_o,
   input logic       tx_half_o,
   input logic       tx_done_o,
   input logic       rx_half_o,
   input logic       rx_done_o,
   input logic [1:0] dbg_o,
   input logic [1:0] state_o
);
   p_clear_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && !stop_i) |=> (state_o == 2'd1 || state_o == 2'd2));

   p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_i |=> tx_valid_o);

   p_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_req_i |=> !tx_valid_o);

   p_clear_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1) |=> (!tx_half_o && !tx_done_o && !rx_half_o && !rx_done_o));

   p_run_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && $past(state_o) == 2'd2) |-> tx_half_o);

   p_rx_evt_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_half_o || rx_done_o) |-> ($past(state_o) == 2'd3));

   p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_half_o |=> !tx_half_o);

   p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_half_o |=> !rx_half_o);

   p_tx_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_half_o && tx_done_o));

   p_tx_evt_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_half_o || tx_done_o) |-> tx_valid_o);

   p_dbg_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_half_o |-> dbg_o[0]) and (tx_done_o |-> !dbg_o[0]));

   p_dbg_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_half_o |-> dbg_o[1]) and (rx_done_o |-> !dbg_o[1]));

   p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (state_o == 2'd0 && dbg_o == 2'd0 && !tx_half_o && !rx_half_o));
endmodule

bind echo_ring_buf echo_ring_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_i     (stop_i),
   .tx_req_i   (tx_req_i),
   .tx_valid_o (tx_valid_o),
   .tx_half_o  (tx_half_o),
   .tx_done_o  (tx_done_o),
   .rx_half_o  (rx_half_o),
   .rx_done_o  (rx_done_o),
   .dbg_o      (dbg_o),
   .state_o    (state_o)
);

// File: tb/echo_ring_buf_tb.sv
module echo_ring_buf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int F          = 1024;
   localparam int HALF       = F / 2;

   logic        clk = 1'b0;
   logic        rst_n, start_i, stop_i, tx_req_i, rx_stb_i;
   logic [31:0] rx_data_i;
   logic        tx_valid_o, tx_half_o, tx_done_o, rx_half_o, rx_done_o;
   logic [31:0] tx_data_o;
   logic [1:0]  dbg_o, state_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   echo_ring_buf u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .tx_req_i   (tx_req_i),
      .tx_valid_o (tx_valid_o),
      .tx_data_o  (tx_data_o),
      .rx_stb_i   (rx_stb_i),
      .rx_data_i  (rx_data_i),
      .tx_half_o  (tx_half_o),
      .tx_done_o  (tx_done_o),
      .rx_half_o  (rx_half_o),
      .rx_done_o  (rx_done_o),
      .dbg_o      (dbg_o),
      .state_o    (state_o)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   // Reference model state, built from the requirements.
   int          m_st = 0;
   int          m_rd = 0;
   int          m_wr = 0;
   logic [31:0] m_mem [F];
   logic [1:0]  m_dbg = 2'b00;
   logic        e_valid, e_txh, e_txd, e_rxh, e_rxd;
   logic [31:0] e_data;
   string       st_tag, d_tag;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] pat(input int s);
      logic [15:0] v;
      v = 16'(s);
      return {v ^ 16'hA5A5, v + 16'h1234};
   endfunction

   task automatic model_step(input logic st, input logic sp, input logic tq,
                             input logic rs, input logic [31:0] rd);
      logic active, capture, clearing, coll;
      active   = (m_st == 2 || m_st == 3) && !sp;
      capture  = (m_st == 3) && rs && !sp;
      clearing = (m_st == 1) && !sp;
      coll     = tq && active && capture && (m_rd == m_wr);
      e_valid  = tq;
      e_data   = (tq && active) ? m_mem[m_rd] : 32'h0;
      d_tag    = coll ? "R10" : (active ? "R3" : "R4");
      e_txh    = tq && active && (m_rd == HALF - 1);
      e_txd    = tq && active && (m_rd == F - 1);
      e_rxh    = capture && (m_wr == HALF - 1);
      e_rxd    = capture && (m_wr == F - 1);
      if (sp) m_dbg = 2'b00;
      else begin
         if (e_txh) m_dbg[0] = 1'b1; else if (e_txd) m_dbg[0] = 1'b0;
         if (e_rxh) m_dbg[1] = 1'b1; else if (e_rxd) m_dbg[1] = 1'b0;
      end
      if (clearing) m_mem[m_wr] = 32'h0;
      if (capture)  m_mem[m_wr] = rd;
      st_tag = sp ? "R11" : "R2";
      if (sp) begin
         m_st = 0; m_rd = 0; m_wr = 0;
      end else begin
         case (m_st)
            0: begin
               m_rd = 0; m_wr = 0;
               if (st) m_st = 1;
            end
            1: begin
               if (m_wr == F - 1) m_st = 2;
               m_wr = (m_wr + 1) % F;
            end
            2: if (e_txh) begin m_st = 3; st_tag = "R5"; end
            default: ;
         endcase
         if (tq && active) m_rd = (m_rd + 1) % F;
         if (capture)      m_wr = (m_wr + 1) % F;
      end
   endtask

   task automatic compare();
      chk(st_tag, 32'(state_o), 32'(m_st));
      chk("R3", 32'(tx_valid_o), 32'(e_valid));
      if (e_valid) chk(d_tag, tx_data_o, e_data);
      chk("R7", {30'h0, tx_half_o, tx_done_o}, {30'h0, e_txh, e_txd});
      chk("R6", {30'h0, rx_half_o, rx_done_o}, {30'h0, e_rxh, e_rxd});
      chk("R8", 32'(dbg_o), 32'(m_dbg));
   endtask

   task automatic run_cyc(input logic st, input logic sp, input logic tq,
                          input logic rs, input logic [31:0] rd);
      start_i = st; stop_i = sp; tx_req_i = tq; rx_stb_i = rs; rx_data_i = rd;
      @(posedge clk);
      model_step(st, sp, tq, rs, rd);
      @(negedge clk);
      compare();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < F; i++) m_mem[i] = 32'h0;
      rst_n = 1'b0; start_i = 0; stop_i = 0; tx_req_i = 0; rx_stb_i = 0; rx_data_i = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", 32'(state_o), 32'd0);
      chk("R1", 32'(tx_valid_o), 32'd0);
      chk("R1", {28'h0, tx_half_o, tx_done_o, rx_half_o, rx_done_o}, 32'd0);
      chk("R1", 32'(dbg_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'(state_o), 32'd0);

      // R4: idle requests answered with zero, capture ignored
      for (int i = 0; i < 20; i++)
         run_cyc(0, 0, 1'($urandom % 2), 1'($urandom % 2), $urandom);

      // R2: start and zero-fill, with random requests (R4) during fill
      run_cyc(1, 0, 1, 0, 32'h0);
      while (m_st == 1)
         run_cyc(0, 0, 1'($urandom % 2), 1'($urandom % 2), $urandom);

      // R9: lockstep playback and capture
      begin
         int slot;
         slot = 0;
         for (int i = 0; i < 3 * F; i++) begin
            bit was_run;
            logic [31:0] d;
            was_run = (m_st == 3);
            d = was_run ? pat(slot) : (32'hFFFF_0000 ^ 32'(i));
            run_cyc(0, 0, 1, 1, d);
            if (was_run) begin
               chk("R9", tx_data_o, (slot >= HALF) ? pat(slot - HALF) : 32'h0);
               slot++;
            end
         end
      end

      // Random request and strobe mix (R3, R6, R7, R8)
      for (int i = 0; i < 5000; i++)
         run_cyc(0, 0, 1'($urandom % 3 != 0), 1'($urandom % 3 != 0), $urandom);

      // R11: stop and start together, stop wins; then again from idle
      run_cyc(1, 1, 1, 1, 32'h1111_2222);
      run_cyc(1, 1, 1, 0, 32'h0);
      chk("R11", 32'(state_o), 32'd0);
      run_cyc(0, 0, 1, 0, 32'h0);
      chk("R4", tx_data_o, 32'h0);

      // R10: force read and write onto the same frame
      run_cyc(1, 0, 0, 0, 32'h0);
      while (m_st == 1) run_cyc(0, 0, 0, 0, 32'h0);
      while (m_st == 2) run_cyc(0, 0, 1, 0, 32'h0);
      for (int i = 0; i < HALF; i++) run_cyc(0, 0, 1, 0, 32'h0);
      run_cyc(0, 0, 1, 1, 32'hDEAD_BEEF);
      chk("R10", tx_data_o, 32'h0);
      for (int i = 0; i < F - 1; i++) run_cyc(0, 0, 1, 0, 32'h0);
      run_cyc(0, 0, 1, 0, 32'h0);
      chk("R10", tx_data_o, 32'hDEAD_BEEF);

      // R11: stop in the middle of running
      for (int i = 0; i < 300; i++)
         run_cyc(0, 0, 1'($urandom % 2), 1'($urandom % 2), $urandom);
      run_cyc(0, 1, 1, 1, 32'h5555_AAAA);
      chk("R11", tx_data_o, 32'h0);
      run_cyc(0, 0, 0, 0, 32'h0);
      chk("R11", 32'(dbg_o), 32'd0);
      for (int i = 0; i < 10; i++) run_cyc(0, 0, 1, 1, $urandom);

      summary();
   end
endmodule